// File: doc/BRIEF.md
# UART Register Front-End with Watermark Interrupts

This block sits between a 32-bit host register bus and the byte streams of a simple serial port. Software writes bytes into an eight-entry transmit queue, which drains onto a byte-wide valid/ready stream toward the serializer. Bytes that the deserializer delivers on a second valid/ready stream land in an eight-entry receive queue, which software drains by reading the receive data register. Each read of that register pops one byte. When the queue is empty, the read reports this in bit 31.

Each direction has a control register with an enable bit and a small watermark count field. A pending register is derived combinationally from those counts and from the receive occupancy. An enable register selects what drives the single level-sensitive interrupt line. A baud divisor register is only stored and is presented on an output for the bit-timing logic outside this block.

The bus is single-cycle. A request is held for one clock. Read data is valid in the same cycle, and any write or pop takes effect at the clock edge that ends the request.

Top module: `uart_reg_front`

## Requirements
- R1: Registers are word-addressed: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 interrupt pending, 0x18 divisor. Control registers keep bit 0 (enable) and bits 18:16 (watermark count) and read back zero elsewhere. Interrupt enable keeps bits 1:0 (bit 0 transmit watermark, bit 1 receive watermark). The divisor keeps its low 16 bits.
- R2: An access is ignored unless all four byte enables are set, address bits 1:0 are zero, and the offset is one of the seven defined. An ignored access reads zero and changes no state.
- R3: A read of receive data while the receive queue holds bytes returns the oldest byte in bits 7:0, with all other bits zero, and removes that byte from the queue.
- R4: A read of receive data while the receive queue is empty returns 0x80000000 and removes nothing.
- R5: A write to transmit data appends bits 7:0 to the transmit queue. The byte is discarded when the queue already holds 8 bytes.
- R6: A read of transmit data returns bit 31 set exactly while the transmit queue holds 8 bytes, and zero in every other bit.
- R7: txValid is high when the transmit enable (transmit control bit 0) is set and the queue is non-empty. txData shows the oldest byte, and a byte leaves on a cycle where txValid and txReady are both high. Bytes leave in write order.
- R8: Pending bit 0 reads 1 when the transmit watermark count is nonzero. Pending bit 1 reads 1 when receive occupancy is strictly greater than the receive watermark count.
- R9: irq is high when interrupt enable bit 0 is set, or when enable bit 1 is set and the receive queue is non-empty. Otherwise irq is low.
- R10: rxReady is high when the receive enable (receive control bit 0) is set and the receive queue holds fewer than 8 bytes. A byte is stored on a cycle where rxValid and rxReady are both high. A byte offered while the queue is full is not stored.
- R11: Reset clears both control registers, interrupt enable, the divisor and both queues, and drives irq low.
- R12: baudDiv always equals the stored divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busByteEn | input | 4 | Byte enables; only 4'hF is legal |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the request cycle |
| txValid | output | 1 | Transmit byte available |
| txReady | input | 1 | Serializer accepts the byte |
| txData | output | 8 | Transmit byte |
| rxValid | input | 1 | Received byte offered |
| rxReady | output | 1 | Receive queue can accept |
| rxData | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |
| baudDiv | output | 16 | Stored baud divisor |

## Verification
On every cycle the assertions check several properties: ignored accesses read zero and leave the divisor alone, an empty receive read returns the empty pattern, a receive read pops exactly one byte, a write to a full transmit queue leaves it full, rxReady is low when the receive queue is full, and txValid is low when the transmit queue is empty. Other behaviour can only be shown by the bench's scenarios. These cover the exact order of bytes through both queues, the dropping of the ninth transmit byte and of bytes offered to a full receive queue, and the full flag clearing after a single drain under backpressure. They also cover the watermark comparisons at the equal and one-below thresholds, the interrupt combinations, and the masking of control-register readback.

// File: rtl/uart_rf_pkg.sv
`timescale 1ns/1ps
package uart_rf_pkg;
  localparam int DATA_W  = 8;
  localparam int CNT_LSB = 16;

  // Order follows the register offsets: word index + 1.
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_TXDATA = 3'd1,
    SEL_RXDATA = 3'd2,
    SEL_TXCTRL = 3'd3,
    SEL_RXCTRL = 3'd4,
    SEL_IE     = 3'd5,
    SEL_IP     = 3'd6,
    SEL_DIV    = 3'd7
  } regSel_t;

  typedef struct packed {
    logic    txPush;
    logic    rxPop;
    logic    txCtrlWr;
    logic    rxCtrlWr;
    logic    ieWr;
    logic    divWr;
    regSel_t rdSel;
  } strobes_t;
endpackage

// File: rtl/uart_rf_fifo.sv
`timescale 1ns/1ps
module uart_rf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (level != LVL_W'(DEPTH));
  assign doPop  = pop && (level != '0);
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rf_ctrl.sv
`timescale 1ns/1ps
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  output strobes_t          stb
);
  logic [IDX_W-1:0] idx;
  logic    legal;
  regSel_t target;

  assign idx = busAddr[ADDR_W-1:2];

  always_comb begin
    legal  = busSel && (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00)
             && (idx <= IDX_W'(6));
    target = legal ? regSel_t'(3'(idx[2:0]) + 3'd1) : SEL_NONE;

    stb          = '0;
    stb.rdSel    = busWrite ? SEL_NONE : target;
    stb.txPush   = busWrite && (target == SEL_TXDATA) && (txLevel != LVL_W'(DEPTH));
    stb.rxPop    = !busWrite && (target == SEL_RXDATA) && (rxLevel != '0);
    stb.txCtrlWr = busWrite && (target == SEL_TXCTRL);
    stb.rxCtrlWr = busWrite && (target == SEL_RXCTRL);
    stb.ieWr     = busWrite && (target == SEL_IE);
    stb.divWr    = busWrite && (target == SEL_DIV);
  end
endmodule

// File: rtl/uart_rf_dpath.sv
`timescale 1ns/1ps
module uart_rf_dpath
  import uart_rf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  output logic              irq,
  output logic [DIV_W-1:0]  baudDiv,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  logic             txEn, rxEn, ieTx, ieRx;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [DIV_W-1:0] divQ;
  logic [DATA_W-1:0] rxHead;
  logic txPop, rxPush, txFull, rxEmpty;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0; txCnt <= '0;
      rxEn <= 1'b0; rxCnt <= '0;
      ieTx <= 1'b0; ieRx  <= 1'b0;
      divQ <= '0;
    end else begin
      if (stb.txCtrlWr) begin
        txEn  <= busWdata[0];
        txCnt <= busWdata[CNT_LSB +: CNT_W];
      end
      if (stb.rxCtrlWr) begin
        rxEn  <= busWdata[0];
        rxCnt <= busWdata[CNT_LSB +: CNT_W];
      end
      if (stb.ieWr) begin
        ieTx <= busWdata[0];
        ieRx <= busWdata[1];
      end
      if (stb.divWr) divQ <= busWdata[DIV_W-1:0];
    end
  end

  assign txFull  = (txLevel == LVL_W'(DEPTH));
  assign rxEmpty = (rxLevel == '0);
  assign txValid = txEn && (txLevel != '0);
  assign txPop   = txValid && txReady;
  assign rxReady = rxEn && (rxLevel != LVL_W'(DEPTH));
  assign rxPush  = rxValid && rxReady;
  assign irq     = ieTx || (ieRx && !rxEmpty);
  assign baudDiv = divQ;

  uart_rf_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .wdata(busWdata[DATA_W-1:0]),
    .pop(txPop), .rdata(txData), .level(txLevel)
  );

  uart_rf_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .wdata(rxData),
    .pop(stb.rxPop), .rdata(rxHead), .level(rxLevel)
  );

  function automatic logic [31:0] ctrlWord(input logic en, input logic [CNT_W-1:0] cnt);
    logic [31:0] w;
    w = '0;
    w[0] = en;
    w[CNT_LSB +: CNT_W] = cnt;
    return w;
  endfunction

  always_comb begin
    unique case (stb.rdSel)
      SEL_TXDATA: busRdata = {txFull, 31'b0};
      SEL_RXDATA: busRdata = rxEmpty ? 32'h8000_0000 : {24'b0, rxHead};
      SEL_TXCTRL: busRdata = ctrlWord(txEn, txCnt);
      SEL_RXCTRL: busRdata = ctrlWord(rxEn, rxCnt);
      SEL_IE:     busRdata = {30'b0, ieRx, ieTx};
      SEL_IP:     busRdata = {30'b0, rxLevel > LVL_W'(rxCnt), txCnt != '0};
      SEL_DIV:    busRdata = 32'(divQ);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_reg_front.sv
`timescale 1ns/1ps
module uart_reg_front
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxData,
  output logic              irq,
  output logic [DIV_W-1:0]  baudDiv
);
  strobes_t         stb;
  logic [LVL_W-1:0] txLevel, rxLevel;

  uart_rf_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busByteEn(busByteEn),
    .txLevel(txLevel), .rxLevel(rxLevel), .stb(stb)
  );

  uart_rf_dpath #(.DEPTH(DEPTH), .DIV_W(DIV_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .irq(irq), .baudDiv(baudDiv), .txLevel(txLevel), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/uart_rf_chk.sv
`timescale 1ns/1ps
module uart_rf_chk #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busByteEn,
  input logic [31:0]       busRdata,
  input logic              txValid,
  input logic              txReady,
  input logic              rxValid,
  input logic              rxReady,
  input logic [DIV_W-1:0]  baudDiv,
  input logic [LVL_W-1:0]  txLevel,
  input logic [LVL_W-1:0]  rxLevel
);
  logic legal, rdRx, wrTx;
  assign legal = busSel && (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00)
                 && (busAddr[ADDR_W-1:2] <= (ADDR_W-2)'(6));
  assign rdRx = legal && !busWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign wrTx = legal && busWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(0));

  // R2
  bad_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !legal) |-> (busRdata == 32'h0));
  // R2
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !legal) |=> $stable(baudDiv));
  // R4
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxLevel == '0) |-> (busRdata == 32'h8000_0000));
  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxLevel != '0 && !(rxValid && rxReady)) |=> (rxLevel == $past(rxLevel) - 1'b1));
  // R5
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && txLevel == LVL_W'(DEPTH) && !(txValid && txReady)) |=> (txLevel == LVL_W'(DEPTH)));
  // R10
  rx_ready_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == LVL_W'(DEPTH)) |-> !rxReady);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= LVL_W'(DEPTH)) && (txLevel <= LVL_W'(DEPTH)));
  // R7
  tx_valid_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == '0) |-> !txValid);
endmodule

bind uart_reg_front uart_rf_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busByteEn(busByteEn), .busRdata(busRdata), .txValid(txValid), .txReady(txReady),
  .rxValid(rxValid), .rxReady(rxReady), .baudDiv(baudDiv),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/tb_uart_reg_front.sv
`timescale 1ns/1ps
module tb_uart_reg_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [3:0] busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic txValid, rxReady, irq;
  logic txReady = 1'b0, rxValid = 1'b0;
  logic [7:0] txData, rxData = '0;
  logic [15:0] baudDiv;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] txExp[$];
  int modelTx = 0;

  always #4 clk = ~clk;

  uart_reg_front dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .irq(irq), .baudDiv(baudDiv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busByteEn = be;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic readChk(input string tag, input logic [4:0] a, input logic [31:0] exp,
                         input logic [3:0] be = 4'hF);
    logic [31:0] d;
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busByteEn = be;
    #1 d = busRdata;
    check(tag, d, exp);
    @(negedge clk);
    busSel = 1'b0; busByteEn = 4'hF;
  endtask

  // Driver: pushes the expected byte when the queue model has room.
  task automatic txPush(input logic [7:0] b);
    regWrite(5'h00, {24'hFFFFFF, b});
    if (modelTx < 8) begin
      txExp.push_back(b);
      modelTx++;
    end
  endtask

  task automatic lineSend(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // Monitor: compares every transmit handshake with the scoreboard.
  always begin
    @(negedge clk);
    #2;
    if (rstN && txValid && txReady) begin
      if (txExp.size() == 0) begin
        check("R7 unexpected tx byte", {24'b0, txData}, 32'hFFFF_FFFF);
      end else begin
        check("R7 tx order", {24'b0, txData}, {24'b0, txExp.pop_front()});
      end
      modelTx--;
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq", {31'b0, irq}, 32'h0);
    check("R11 txValid", {31'b0, txValid}, 32'h0);
    check("R11 rxReady", {31'b0, rxReady}, 32'h0);
    check("R11 baudDiv", {16'b0, baudDiv}, 32'h0);
    readChk("R11 txctrl", 5'h08, 32'h0);
    readChk("R11 rxctrl", 5'h0C, 32'h0);
    readChk("R11 ie", 5'h10, 32'h0);
    readChk("R11 div", 5'h18, 32'h0);
    readChk("R11 rx queue empty", 5'h04, 32'h8000_0000);
    readChk("R11 tx queue not full", 5'h00, 32'h0);

    // R1 register map and field masking
    regWrite(5'h08, 32'hFFFF_FFFE);
    readChk("R1 txctrl mask", 5'h08, 32'h0007_0000);
    regWrite(5'h0C, 32'h0005_0000);
    readChk("R1 rxctrl", 5'h0C, 32'h0005_0000);
    regWrite(5'h10, 32'hFFFF_FFFC);
    readChk("R1 ie mask", 5'h10, 32'h0);
    regWrite(5'h18, 32'hABCD_1234);
    readChk("R1 div", 5'h18, 32'h0000_1234);
    check("R12 baudDiv", {16'b0, baudDiv}, 32'h0000_1234);
    // R8 tx count nonzero, rx occupancy 0 not above 5
    readChk("R8 ip tx bit", 5'h14, 32'h1);

    // R2 ignored accesses
    regWrite(5'h18, 32'h0000_5555, 4'h3);
    readChk("R2 partial write ignored", 5'h18, 32'h0000_1234);
    regWrite(5'h19, 32'h0000_7777);
    check("R2 unaligned write ignored", {16'b0, baudDiv}, 32'h0000_1234);
    readChk("R2 undefined offset", 5'h1C, 32'h0);
    readChk("R2 partial read", 5'h08, 32'h0, 4'h1);

    regWrite(5'h08, 32'h0);
    readChk("R8 ip clear", 5'h14, 32'h0);

    // R4 empty reads
    readChk("R4 empty read", 5'h04, 32'h8000_0000);
    readChk("R4 empty read again", 5'h04, 32'h8000_0000);

    // R10 / R3 / R8 receive path and watermark thresholds
    regWrite(5'h0C, 32'h0000_0001);
    check("R10 rxReady enabled", {31'b0, rxReady}, 32'h1);
    lineSend(8'h11); lineSend(8'h22); lineSend(8'h33);
    readChk("R8 rx above 0", 5'h14, 32'h2);
    regWrite(5'h0C, 32'h0003_0001);
    readChk("R8 rx equal 3", 5'h14, 32'h0);
    regWrite(5'h0C, 32'h0002_0001);
    readChk("R8 rx above 2", 5'h14, 32'h2);
    readChk("R3 first byte", 5'h04, 32'h11);
    readChk("R3 second byte", 5'h04, 32'h22);
    readChk("R3 third byte", 5'h04, 32'h33);
    readChk("R4 after drain", 5'h04, 32'h8000_0000);

    // R10 full receive queue drops bytes
    for (int i = 0; i < 8; i++) lineSend(8'hA0 + 8'(i));
    check("R10 rxReady full", {31'b0, rxReady}, 32'h0);
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hEE;
    repeat (3) @(negedge clk);
    rxValid = 1'b0;
    for (int i = 0; i < 8; i++) readChk("R10 stored byte", 5'h04, 32'hA0 + i);
    readChk("R10 dropped byte absent", 5'h04, 32'h8000_0000);

    // R9 interrupt combinations
    regWrite(5'h10, 32'h0);
    check("R9 none enabled", {31'b0, irq}, 32'h0);
    regWrite(5'h10, 32'h2);
    check("R9 rx enable, empty", {31'b0, irq}, 32'h0);
    lineSend(8'h5A);
    check("R9 rx enable, byte", {31'b0, irq}, 32'h1);
    readChk("R3 irq byte", 5'h04, 32'h5A);
    check("R9 rx drained", {31'b0, irq}, 32'h0);
    regWrite(5'h10, 32'h1);
    check("R9 tx enable", {31'b0, irq}, 32'h1);
    regWrite(5'h10, 32'h0);
    check("R9 disabled", {31'b0, irq}, 32'h0);

    // R5 / R6 / R7 transmit fill, drop and drain
    txReady = 1'b1;
    for (int i = 0; i < 9; i++) txPush(8'hC0 + 8'(i));
    check("R7 disabled holds", {31'b0, txValid}, 32'h0);
    readChk("R6 full flag", 5'h00, 32'h8000_0000);
    regWrite(5'h08, 32'h1);
    repeat (20) @(negedge clk);
    check("R5 ninth byte dropped", txExp.size(), 32'h0);
    readChk("R6 empty flag", 5'h00, 32'h0);

    // R6 / R7 backpressure: full flag clears after one departure
    regWrite(5'h08, 32'h0);
    txReady = 1'b0;
    for (int i = 0; i < 8; i++) txPush(8'hD0 + 8'(i));
    regWrite(5'h08, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 valid under backpressure", {31'b0, txValid}, 32'h1);
    check("R7 head byte", {24'b0, txData}, 32'hD0);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    readChk("R6 flag clears", 5'h00, 32'h0);
    txPush(8'hDF);
    readChk("R6 full again", 5'h00, 32'h8000_0000);
    txReady = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 drained", txExp.size(), 32'h0);
    check("R7 idle", {31'b0, txValid}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule